// File: doc/BRIEF.md
# Prioritized Masked Interrupt Request Core

This block gathers eight interrupt request lines into a pending register, filters them through a software-written mask and resolves the survivors with a fixed priority. Input 0 has the highest priority and input 7 the lowest. When the best unmasked pending level outranks everything already in service, an active-high interrupt line to the processor is raised.

A single-cycle acknowledge pulse moves the winning level from pending to in-service. An in-service level blocks every request of equal or lower priority. A non-specific end-of-interrupt command clears the highest-priority in-service level.

Software reaches the block through an 8-bit port. The port has an active-low chip select, active-low read and write strobes and one address bit. Each clock cycle in which chip select and a strobe are both low performs one access.

- At address 1, a write sets the mask and a read returns it.
- At address 0, a write is a command byte. A read returns either the pending register or the in-service register, depending on a read-select flag that a command sets.

Top module: `irq_prio_core`

## Requirements
- R1: A request bit is set in the pending register on the clock edge after its input goes from 0 to 1. An input that stays high does not set the bit again after the level has been taken into service.
- R2: The mask register resets to 0x00. It is written by a port write at address 1 and read back by a port read at address 1.
- R3: A request on a masked level is still set in the pending register, but it never raises int_o and is never acknowledged. Clearing the mask bit later makes it eligible.
- R4: Priority is fixed, with level 0 highest and level 7 lowest. An acknowledge pulse (ack_i high for one cycle while int_o is high) sets the in-service bit of the lowest-numbered unmasked pending level and clears that level's pending bit.
- R5: int_o is high exactly when some unmasked level is pending and its number is strictly lower than every set in-service bit. An in-service level blocks pending levels of equal or lower priority.
- R6: An acknowledge pulse while int_o is low changes neither the pending register nor the in-service register.
- R7: A command write at address 0 with bit 5 set is an end-of-interrupt. It clears only the lowest-numbered set in-service bit.
- R8: A command write at address 0 with bit 3 set loads the read-select flag from bit 0. A read at address 0 then returns the pending register when the flag is 0 and the in-service register when the flag is 1.
- R9: Accesses happen only while cs_n_i is low. A write with cs_n_i high changes nothing, and rdata_o is 0x00 whenever no read is active.
- R10: After reset the pending, in-service and mask registers are all zero, int_o is low and the read-select flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 8 | Interrupt request lines, rising-edge recognised |
| ack_i | input | 1 | One-cycle interrupt acknowledge pulse |
| cs_n_i | input | 1 | Port chip select, active low |
| rd_n_i | input | 1 | Port read strobe, active low |
| wr_n_i | input | 1 | Port write strobe, active low |
| addr_i | input | 1 | Port address: 0 command/status, 1 mask |
| wdata_i | input | 8 | Port write data |
| rdata_o | output | 8 | Port read data, zero when no read is active |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The bench sweeps every request pattern under several masks and drains each pattern one acknowledge at a time. This catches a resolver with reversed or off-by-one priority, which would service the wrong bit first, and a mask applied at latching rather than resolution, which would lose masked pending bits. Nested service is driven so that a higher level arrives while a lower one is in service and an equal level re-arrives. A comparison written as "less or equal" would raise int_o for the re-arrived level, and an end-of-interrupt that cleared the wrong bit would unblock it too early. Directed cases also cover held inputs that must not re-latch, acknowledges while int_o is idle, and writes without chip select.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Command byte fields written at port address 0
  localparam int CMD_EOI_BIT     = 5;
  localparam int CMD_SEL_WE_BIT  = 3;
  localparam int CMD_SEL_VAL_BIT = 0;

  localparam logic ADDR_CMD  = 1'b0;
  localparam logic ADDR_MASK = 1'b1;

  typedef enum logic {
    RDSEL_PEND = 1'b0,
    RDSEL_SVC  = 1'b1
  } rdsel_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int NUM_LVL = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] req_i,
  input  logic [NUM_LVL-1:0] clr_i,
  output logic [NUM_LVL-1:0] pend_o
);
  logic [NUM_LVL-1:0] prev_q, prev_d;
  logic [NUM_LVL-1:0] pend_q, pend_d;
  logic [NUM_LVL-1:0] rise;

  always_comb begin
    rise   = req_i & ~prev_q;
    prev_d = req_i;
    // a fresh edge wins over a same-cycle clear
    pend_d = (pend_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R1
  new_bit_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(req_i)) == '0);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LVL = 8,
  localparam int IDX_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic [NUM_LVL-1:0] req_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_LVL-1:0] onehot_o
);
  always_comb begin
    valid_o  = 1'b0;
    idx_o    = '0;
    onehot_o = '0;
    // walk from the lowest priority upward so level 0 wins last
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o  = 1'b1;
        idx_o    = IDX_W'(i);
        onehot_o = NUM_LVL'(1) << i;
      end
    end
  end
endmodule

// File: rtl/irq_host_port.sv
module irq_host_port
  import irq_pkg::*;
#(
  parameter int NUM_LVL = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_i,
  input  logic               rd_n_i,
  input  logic               wr_n_i,
  input  logic               addr_i,
  input  logic [NUM_LVL-1:0] wdata_i,
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic [NUM_LVL-1:0] svc_i,
  output logic [NUM_LVL-1:0] mask_o,
  output logic               eoi_o,
  output logic [NUM_LVL-1:0] rdata_o
);
  logic               wr_act, rd_act, mask_we, cmd_we, sel_we;
  logic [NUM_LVL-1:0] mask_q, mask_d;
  rdsel_e             sel_q, sel_d;

  always_comb begin
    wr_act  = !cs_n_i && !wr_n_i;
    rd_act  = !cs_n_i && !rd_n_i;
    mask_we = wr_act && (addr_i == ADDR_MASK);
    cmd_we  = wr_act && (addr_i == ADDR_CMD);
    eoi_o   = cmd_we && wdata_i[CMD_EOI_BIT];
    sel_we  = cmd_we && wdata_i[CMD_SEL_WE_BIT];
    mask_d  = mask_we ? wdata_i : mask_q;
    sel_d   = sel_we ? rdsel_e'(wdata_i[CMD_SEL_VAL_BIT]) : sel_q;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_act) begin
      if (addr_i == ADDR_MASK)   rdata_o = mask_q;
      else if (sel_q == RDSEL_SVC) rdata_o = svc_i;
      else                       rdata_o = pend_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      sel_q  <= RDSEL_PEND;
    end else begin
      mask_q <= mask_d;
      sel_q  <= sel_d;
    end
  end

  assign mask_o = mask_q;

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && !wr_n_i && addr_i == ADDR_MASK) |=> (mask_o == $past(wdata_i)));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> $stable(mask_o));

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i || rd_n_i) |-> (rdata_o == '0));
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int NUM_LVL = 8,
  localparam int IDX_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] irq_req_i,
  input  logic               ack_i,
  input  logic               cs_n_i,
  input  logic               rd_n_i,
  input  logic               wr_n_i,
  input  logic               addr_i,
  input  logic [NUM_LVL-1:0] wdata_i,
  output logic [NUM_LVL-1:0] rdata_o,
  output logic               int_o
);
  logic [NUM_LVL-1:0] pend, mask, cand;
  logic [NUM_LVL-1:0] svc_q, svc_d;
  logic [NUM_LVL-1:0] p_onehot, s_onehot, take, drop, at_or_above;
  logic [IDX_W-1:0]   p_idx, s_idx;
  logic               p_valid, s_valid, eoi, int_c, ack_go;

  irq_edge_latch #(.NUM_LVL(NUM_LVL)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (irq_req_i),
    .clr_i  (take),
    .pend_o (pend)
  );

  assign cand = pend & ~mask;

  irq_prio_pick #(.NUM_LVL(NUM_LVL)) u_pick_pend (
    .req_i    (cand),
    .valid_o  (p_valid),
    .idx_o    (p_idx),
    .onehot_o (p_onehot)
  );

  irq_prio_pick #(.NUM_LVL(NUM_LVL)) u_pick_svc (
    .req_i    (svc_q),
    .valid_o  (s_valid),
    .idx_o    (s_idx),
    .onehot_o (s_onehot)
  );

  irq_host_port #(.NUM_LVL(NUM_LVL)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_i  (cs_n_i),
    .rd_n_i  (rd_n_i),
    .wr_n_i  (wr_n_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pend_i  (pend),
    .svc_i   (svc_q),
    .mask_o  (mask),
    .eoi_o   (eoi),
    .rdata_o (rdata_o)
  );

  always_comb begin
    int_c  = p_valid && (!s_valid || (p_idx < s_idx));
    ack_go = ack_i && int_c;
    take   = ack_go ? p_onehot : '0;
    drop   = eoi ? s_onehot : '0;
    svc_d  = (svc_q & ~drop) | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  assign int_o = int_c;

  // levels 0..winner, used to check the strict-priority rule
  assign at_or_above = {p_onehot[NUM_LVL-2:0], 1'b0} - {{(NUM_LVL-1){1'b0}}, 1'b1};

  // R3
  int_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((pend & ~mask) != '0));

  // R5
  int_strict_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((svc_q & at_or_above) == '0));

  // R4
  ack_enters_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o) |=> ((svc_q & $past(p_onehot)) != '0));

  // R6
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o && !eoi) |=> (svc_q == $past(svc_q)));

  // R7
  eoi_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_i && (svc_q != '0)) |=>
      ($countones(svc_q) + 1 == $countones($past(svc_q))));
endmodule

// File: tb/irq_prio_core_bench.sv
module irq_prio_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic       ack = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       int_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_core u_irq_prio_core (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .ack_i(ack),
    .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .int_o(int_o)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_req = '0; ack = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic port_wr(input logic a, input logic [7:0] d);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic port_rd(input logic a, output logic [7:0] v);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 v = rdata;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    irq_req = v;
    @(negedge clk);
  endtask

  function automatic int lowest(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) lowest = i;
  endfunction

  task automatic chk_int(input logic exp, input string req);
    #1 chk(int_o === exp, req, {7'b0, int_o}, {7'b0, exp});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v, m, exp_pend, unm;
    int w;

    // R10 reset state
    do_reset();
    chk_int(1'b0, "R10 int after reset");
    port_rd(1'b0, v); chk(v == 8'h00, "R10 pending after reset", v, 8'h00);
    port_rd(1'b1, v); chk(v == 8'h00, "R10 mask after reset", v, 8'h00);
    @(negedge clk);
    port_wr(1'b0, 8'h09);
    port_rd(1'b0, v); chk(v == 8'h00, "R10 svc after reset", v, 8'h00);

    // R1 R3 R4 R5 R7 R8: sweep every request pattern under several masks
    for (int mi = 0; mi < 4; mi++) begin
      case (mi)
        0: m = 8'h00;
        1: m = 8'hFF;
        2: m = 8'hA5;
        default: m = 8'h3C;
      endcase
      for (int pat = 0; pat < 256; pat++) begin
        do_reset();
        port_wr(1'b1, m);
        set_irq(pat[7:0]);
        port_rd(1'b0, v);
        chk(v == pat[7:0], "R1 R3 pending latched", v, pat[7:0]);
        @(negedge clk);
        exp_pend = pat[7:0];
        for (int r = 0; r < 9; r++) begin
          unm = exp_pend & ~m;
          chk_int(unm != 0, "R5 R3 int vs unmasked pending");
          @(negedge clk);
          if (unm == 0) break;
          w = lowest(unm);
          pulse_ack();
          exp_pend[w] = 1'b0;
          chk_int(1'b0, "R5 lower levels blocked");
          @(negedge clk);
          port_wr(1'b0, 8'h09);
          port_rd(1'b0, v);
          chk(v == (8'h01 << w), "R4 R8 svc holds winner", v, 8'h01 << w);
          @(negedge clk);
          port_wr(1'b0, 8'h28);
          port_rd(1'b0, v);
          chk(v == exp_pend, "R4 R8 pending after ack", v, exp_pend);
          @(negedge clk);
        end
        chk(exp_pend == (pat[7:0] & m), "R3 masked stay pending", exp_pend, pat[7:0] & m);
      end
    end

    // R1 held input does not re-latch
    do_reset();
    set_irq(8'h04);
    pulse_ack();
    port_wr(1'b0, 8'h20);
    port_rd(1'b0, v); chk(v == 8'h00, "R1 held input no relatch", v, 8'h00);
    chk_int(1'b0, "R1 int stays low while held");
    @(negedge clk);
    set_irq(8'h00); set_irq(8'h04);
    port_rd(1'b0, v); chk(v == 8'h04, "R1 new edge latches", v, 8'h04);
    @(negedge clk);

    // R5 R7 nesting
    do_reset();
    set_irq(8'h20);
    pulse_ack();
    chk_int(1'b0, "R5 nothing left pending");
    @(negedge clk);
    set_irq(8'h24);
    chk_int(1'b1, "R5 higher level preempts");
    @(negedge clk);
    pulse_ack();
    set_irq(8'h04); set_irq(8'h24);
    port_wr(1'b0, 8'h09);
    port_rd(1'b0, v); chk(v == 8'h24, "R4 nested svc", v, 8'h24);
    @(negedge clk);
    port_wr(1'b0, 8'h20);
    port_rd(1'b0, v); chk(v == 8'h20, "R7 eoi clears highest only", v, 8'h20);
    chk_int(1'b0, "R5 equal level blocked");
    @(negedge clk);
    port_wr(1'b0, 8'h20);
    port_rd(1'b0, v); chk(v == 8'h00, "R7 second eoi", v, 8'h00);
    chk_int(1'b1, "R5 released after eoi");
    @(negedge clk);

    // R6 R3 ack while idle, then unmask
    do_reset();
    port_wr(1'b1, 8'hFF);
    set_irq(8'h01);
    pulse_ack();
    port_rd(1'b0, v); chk(v == 8'h01, "R6 pending unchanged", v, 8'h01);
    @(negedge clk);
    port_wr(1'b0, 8'h09);
    port_rd(1'b0, v); chk(v == 8'h00, "R6 svc unchanged", v, 8'h00);
    @(negedge clk);
    port_wr(1'b1, 8'h00);
    chk_int(1'b1, "R3 unmask releases request");
    @(negedge clk);

    // R2 R9 mask access and chip select
    do_reset();
    port_wr(1'b1, 8'h5A);
    port_rd(1'b1, v); chk(v == 8'h5A, "R2 mask readback", v, 8'h5A);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 1'b1; wdata = 8'hFF;
    @(negedge clk);
    wr_n = 1'b1;
    port_rd(1'b1, v); chk(v == 8'h5A, "R9 write without select ignored", v, 8'h5A);
    cs_n = 1'b1; rd_n = 1'b0; addr = 1'b1;
    #1 chk(rdata == 8'h00, "R9 read without select", rdata, 8'h00);
    rd_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule